// File: doc/BRIEF.md
# Dual-Register Programmable Ranging Code Generator

This block generates a pseudo-random ranging code, one chip for each clock on which a chip-enable input is high. It holds two 14-bit shift registers. Software sets their starting states, which bits of each register feed back and which bits form the output chip. All of this is written through a simple register-write port. With these settings the same hardware can produce m-sequences and Gold-style codes.

A mode input picks between two arrangements. In the split arrangement the two registers run as independent generators. In the chained arrangement they form one 28-bit register, which can host a 27-bit Fibonacci generator.

A programmable code-length counter marks the end of each code period. At that point the block reloads the starting states and pulses an epoch output. A restart strobe forces the same reload at any time. Configuration writes are held in a staging bank and only become active at a reload, so a code already in progress is never disturbed.

Top module: `dual_lfsr_codegen`

## Requirements
- R1: After reset, chip_o is 0 and epoch_o is 0. Both stay 0 while chip_en_i pulses, until a reload with a nonzero configuration.
- R2: A write with cfg_we high stores cfg_wdata in a staging slot chosen by cfg_addr. The slots are: 0 starting state of register A, 1 starting state of register B, 2 feedback mask A, 3 feedback mask B, 4 output mask A, 5 output mask B, 6 code length (low 20 bits). Masks and states use the low 14 bits. Staged values, and the level of mode_i, have no effect on the chips until the next reload.
- R3: On a clock edge with restart_i high, the staged settings become active, the staged starting states are copied into the registers and the length counter clears. restart_i takes precedence over chip_en_i in the same cycle: no shift happens on that edge.
- R4: The registers shift only on clock edges where chip_en_i is high. Otherwise they and chip_o hold their values.
- R5: Split mode (mode_i low at reload): each register shifts toward its MSB. Its LSB takes the parity of its own bits selected by its own feedback mask.
- R6: Chained mode (mode_i high at reload): both registers shift toward their MSBs. B's LSB takes A's MSB. A's LSB takes the parity of (A AND feedback mask A) XOR the parity of (B AND feedback mask B).
- R7: chip_o is the parity of (A AND output mask A) XOR the parity of (B AND output mask B), taken from the current register contents.
- R8: After the active code length of enabled chips since the last reload, the counter reloads the registers from the staged starting states and activates the staged settings. epoch_o is high for exactly the one cycle that follows that edge.
- R9: In chained mode with feedback masks A=0x153C and B=0x1252, output masks A=0 and B=0x1000, the chips equal the last stage of the 27-stage Fibonacci register with taps 3,4,5,6,9,11,13,16,19,21,24,27. Stage k is loaded from bit k-1 of the 27-bit start value: bits 0..13 go to A, bits 14..26 go to B bits 0..12.
- R10: In split mode with both starting states 0x3FF, feedback masks 0x204 and 0x3A6, and output masks 0x200 and 0x022, the first ten chips are 1,1,0,0,1,0,0,0,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Staging slot select |
| cfg_wdata | input | 20 | Configuration write data |
| mode_i | input | 1 | 0 split, 1 chained; sampled at reload |
| restart_i | input | 1 | Forces a reload on this edge |
| chip_en_i | input | 1 | Advances one chip on this edge |
| chip_o | output | 1 | Current code chip |
| epoch_o | output | 1 | One-cycle pulse after a terminal-count reload |

## Verification
A wrong feedback bit or a broken link between the registers corrupts chip_o within a few chips. It then stays wrong against a stage-level model of the register, so long compares against independent models expose it quickly. A length counter that is off by one moves epoch_o, and the reload it triggers repeats a short code early. Both show within one short programmed period. Leaks from the staging bank, or a mode switch that takes effect mid-code, break the running sequence at the very next chip. They are caught by writing new settings and flipping the mode partway through a code.

// File: rtl/codegen_pkg.sv
package codegen_pkg;
  typedef enum logic [2:0] {
    SLOT_INIT_A = 3'd0,
    SLOT_INIT_B = 3'd1,
    SLOT_FB_A   = 3'd2,
    SLOT_FB_B   = 3'd3,
    SLOT_OUT_A  = 3'd4,
    SLOT_OUT_B  = 3'd5,
    SLOT_LEN    = 3'd6
  } cfg_slot_e;

  typedef enum logic {
    ARR_SPLIT = 1'b0,
    ARR_CHAIN = 1'b1
  } arrangement_e;
endpackage

// File: rtl/cfg_bank.sv
module cfg_bank
  import codegen_pkg::*;
#(
  parameter int W     = 14,
  parameter int LEN_W = 20,
  parameter int CFG_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [2:0]          addr,
  input  logic [CFG_W-1:0]    wdata,
  input  logic                load,
  input  logic                mode_req,
  output logic [1:0][W-1:0]   stg_init,
  output logic [1:0][W-1:0]   act_fb,
  output logic [1:0][W-1:0]   act_out,
  output logic [LEN_W-1:0]    act_len,
  output arrangement_e        act_mode
);
  logic [1:0][W-1:0] stg_fb, stg_out;
  logic [LEN_W-1:0]  stg_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_init <= '0;
      stg_fb   <= '0;
      stg_out  <= '0;
      stg_len  <= '0;
    end else if (we) begin
      case (cfg_slot_e'(addr))
        SLOT_INIT_A: stg_init[0] <= wdata[W-1:0];
        SLOT_INIT_B: stg_init[1] <= wdata[W-1:0];
        SLOT_FB_A:   stg_fb[0]   <= wdata[W-1:0];
        SLOT_FB_B:   stg_fb[1]   <= wdata[W-1:0];
        SLOT_OUT_A:  stg_out[0]  <= wdata[W-1:0];
        SLOT_OUT_B:  stg_out[1]  <= wdata[W-1:0];
        SLOT_LEN:    stg_len     <= wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_fb   <= '0;
      act_out  <= '0;
      act_len  <= '0;
      act_mode <= ARR_SPLIT;
    end else if (load) begin
      act_fb   <= stg_fb;
      act_out  <= stg_out;
      act_len  <= stg_len;
      act_mode <= arrangement_e'(mode_req);
    end
  end

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_fb) && $stable(act_out) && $stable(act_len) && $stable(act_mode)));
endmodule

// File: rtl/lfsr_pair.sv
module lfsr_pair
  import codegen_pkg::*;
#(
  parameter int W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  arrangement_e      arr,
  input  logic [1:0][W-1:0] init,
  input  logic [1:0][W-1:0] fb_mask,
  input  logic [1:0][W-1:0] out_mask,
  output logic              chip
);
  logic [1:0][W-1:0] sr_q, sr_nxt;
  logic [1:0]        fb_par, out_par;
  logic [1:0]        lsb_in;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign fb_par[g]  = ^(sr_q[g] & fb_mask[g]);
    assign out_par[g] = ^(sr_q[g] & out_mask[g]);
    assign sr_nxt[g]  = {sr_q[g][W-2:0], lsb_in[g]};

    always_ff @(posedge clk) begin
      if (!rst_n)     sr_q[g] <= '0;
      else if (load)  sr_q[g] <= init[g];
      else if (shift) sr_q[g] <= sr_nxt[g];
    end
  end

  always_comb begin
    if (arr == ARR_CHAIN) begin
      lsb_in[0] = fb_par[0] ^ fb_par[1];
      lsb_in[1] = sr_q[0][W-1];
    end else begin
      lsb_in = fb_par;
    end
  end

  assign chip = out_par[0] ^ out_par[1];

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> ($stable(sr_q) && $stable(chip)));

  // R6
  chain_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load && arr == ARR_CHAIN) |=> (sr_q[1][0] == $past(sr_q[0][W-1])));
endmodule

// File: rtl/epoch_ctr.sv
module epoch_ctr #(
  parameter int LEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             shift,
  input  logic [LEN_W-1:0] len,
  output logic             wrap,
  output logic             epoch
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] last_idx;

  assign last_idx = LEN_W'(len - 1'b1);
  assign wrap     = shift && (cnt_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      epoch <= 1'b0;
    end else begin
      epoch <= wrap;
      if (restart || wrap) cnt_q <= '0;
      else if (shift)      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len != '0) |-> (cnt_q < len));

  // R8
  epoch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |-> (cnt_q == '0));
endmodule

// File: rtl/dual_lfsr_codegen.sv
module dual_lfsr_codegen
  import codegen_pkg::*;
#(
  parameter  int W     = 14,
  parameter  int LEN_W = 20,
  localparam int CFG_W = (W > LEN_W) ? W : LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mode_i,
  input  logic             restart_i,
  input  logic             chip_en_i,
  output logic             chip_o,
  output logic             epoch_o
);
  logic              shift, wrap, load;
  logic [1:0][W-1:0] stg_init, act_fb, act_out;
  logic [LEN_W-1:0]  act_len;
  arrangement_e      act_mode;

  assign shift = chip_en_i && !restart_i;
  assign load  = restart_i || wrap;

  cfg_bank #(.W(W), .LEN_W(LEN_W), .CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .load     (load),
    .mode_req (mode_i),
    .stg_init (stg_init),
    .act_fb   (act_fb),
    .act_out  (act_out),
    .act_len  (act_len),
    .act_mode (act_mode)
  );

  epoch_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart_i),
    .shift   (shift),
    .len     (act_len),
    .wrap    (wrap),
    .epoch   (epoch_o)
  );

  lfsr_pair #(.W(W)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift    (shift),
    .arr      (act_mode),
    .init     (stg_init),
    .fb_mask  (act_fb),
    .out_mask (act_out),
    .chip     (chip_o)
  );

  // R3
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !epoch_o);
endmodule

// File: tb/sim_dual_lfsr_codegen.sv
`timescale 1ns/100ps
module sim_dual_lfsr_codegen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic        mode_i = 1'b0;
  logic        restart_i = 1'b0;
  logic        chip_en_i = 1'b0;
  logic        chip_o, epoch_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dual_lfsr_codegen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode_i(mode_i), .restart_i(restart_i),
    .chip_en_i(chip_en_i), .chip_o(chip_o), .epoch_o(epoch_o)
  );

  // independent stage-level models
  logic ca1 [1:10];
  logic ca2 [1:10];
  logic st27 [1:27];
  logic [13:0] sp_a;
  int taps27 [12] = '{3, 4, 5, 6, 9, 11, 13, 16, 19, 21, 24, 27};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int slot, input logic [19:0] val);
    cfg_we = 1'b1; cfg_addr = 3'(slot); cfg_wdata = val;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_restart();
    restart_i = 1'b1;
    tick();
    restart_i = 1'b0;
  endtask

  task automatic ca_reset();
    for (int i = 1; i <= 10; i++) begin ca1[i] = 1'b1; ca2[i] = 1'b1; end
  endtask

  function automatic logic ca_chip();
    return ca1[10] ^ ca2[2] ^ ca2[6];
  endfunction

  task automatic ca_step();
    logic f1, f2;
    f1 = ca1[3] ^ ca1[10];
    f2 = ca2[2] ^ ca2[3] ^ ca2[6] ^ ca2[8] ^ ca2[9] ^ ca2[10];
    for (int i = 10; i > 1; i--) begin ca1[i] = ca1[i-1]; ca2[i] = ca2[i-1]; end
    ca1[1] = f1; ca2[1] = f2;
  endtask

  task automatic l27_init(input logic [26:0] v);
    for (int k = 1; k <= 27; k++) st27[k] = v[k-1];
  endtask

  task automatic l27_step();
    logic f;
    f = 1'b0;
    for (int t = 0; t < 12; t++) f ^= st27[taps27[t]];
    for (int k = 27; k > 1; k--) st27[k] = st27[k-1];
    st27[1] = f;
  endtask

  task automatic t_reset();
    chk("R1 chip after reset", chip_o, 1'b0);
    chk("R1 epoch after reset", epoch_o, 1'b0);
    chip_en_i = 1'b1;
    repeat (3) tick();
    chip_en_i = 1'b0;
    chk("R1 chip unloaded", chip_o, 1'b0);
    chk("R1 epoch unloaded", epoch_o, 1'b0);
  endtask

  task automatic t_gold_and_epoch();
    logic [9:0] head;
    int bad;
    head = 10'b1100100000;
    wr(0, 20'h3FF); wr(1, 20'h3FF); wr(2, 20'h204); wr(3, 20'h3A6);
    wr(4, 20'h200); wr(5, 20'h022); wr(6, 20'd1023);
    mode_i = 1'b0;
    pulse_restart();
    ca_reset();
    chip_en_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      chk("R10 split head chip", chip_o, head[9-k]);
      ca_step();
      tick();
    end
    bad = 0;
    for (int k = 10; k < 1023; k++) begin
      if (chip_o !== ca_chip()) bad++;
      if (epoch_o !== 1'b0) bad++;
      ca_step();
      tick();
    end
    chk_int("R5 R7 split sequence mismatches", bad, 0);
    chk("R8 epoch after length", epoch_o, 1'b1);
    chk("R8 first chip after wrap", chip_o, 1'b1);
    ca_reset();
    ca_step();
    tick();
    chk("R8 epoch single cycle", epoch_o, 1'b0);
  endtask

  task automatic t_hold();
    logic held;
    int bad;
    chip_en_i = 1'b0;
    held = chip_o;
    bad = 0;
    repeat (6) begin
      tick();
      if (chip_o !== held || epoch_o !== 1'b0) bad++;
    end
    chk_int("R4 idle changes", bad, 0);
    chip_en_i = 1'b1;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (chip_o !== ca_chip()) bad++;
      ca_step();
      tick();
    end
    chk_int("R4 resume mismatches", bad, 0);
    chip_en_i = 1'b0;
  endtask

  task automatic t_chain();
    logic [26:0] v;
    int bad;
    v = 27'h5A3C1F7;
    wr(0, {6'd0, v[13:0]});
    wr(1, {7'd0, v[26:14]});
    wr(2, 20'h153C); wr(3, 20'h1252);
    wr(4, 20'h0);    wr(5, 20'h1000);
    wr(6, 20'd10230);
    mode_i = 1'b1;
    pulse_restart();
    l27_init(v);
    chk("R6 chained first chip", chip_o, v[26]);
    chip_en_i = 1'b1;
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      if (chip_o !== st27[27]) bad++;
      l27_step();
      tick();
    end
    chk_int("R9 chained sequence mismatches", bad, 0);
    chip_en_i = 1'b0;
  endtask

  task automatic t_staging_and_restart();
    int bad;
    logic [4:0] first;
    wr(0, 20'h1234); wr(1, 20'h0ABC); wr(2, 20'h3FFF); wr(3, 20'h0001);
    wr(4, 20'h0001); wr(5, 20'h0000); wr(6, 20'd5);
    mode_i = 1'b0;
    chip_en_i = 1'b1;
    bad = 0;
    for (int k = 0; k < 100; k++) begin
      if (chip_o !== st27[27]) bad++;
      if (epoch_o !== 1'b0) bad++;
      l27_step();
      tick();
    end
    chk_int("R2 staged writes leaked", bad, 0);
    restart_i = 1'b1;
    tick();
    restart_i = 1'b0;
    sp_a = 14'h1234;
    chk("R3 restart wins over chip enable", chip_o, sp_a[0]);
    chk("R3 no epoch on restart", epoch_o, 1'b0);
    for (int k = 0; k < 5; k++) begin
      first[k] = sp_a[0];
      chk("R5 split own feedback", chip_o, sp_a[0]);
      chk("R8 no early epoch", epoch_o, 1'b0);
      sp_a = {sp_a[12:0], ^sp_a};
      tick();
    end
    chk("R8 epoch at length five", epoch_o, 1'b1);
    for (int k = 0; k < 5; k++) begin
      chk("R8 reload repeats code", chip_o, first[k]);
      tick();
    end
    chip_en_i = 1'b0;
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_gold_and_epoch();
    t_hold();
    t_chain();
    t_staging_and_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule